// File: doc/BRIEF.md
# Auto-Scan Chirp Scheduler with Beam-Ready Stall

This block sets the pulse timing for a radar transmitter and receiver. It runs in one clock domain and steps through three waveform classes, SHORT, MEDIUM and LONG, without stopping. Each class gets a sub-frame of a fixed number of chirps. For every chirp the block raises a one-cycle `chirp_pulse` and drives a 2-bit waveform code that downstream logic uses to choose its sample tables and filters. Each chirp has a transmit phase and a listen phase, and each class sets its own length for both, counted in clock cycles. When the last enabled sub-frame finishes, the block raises a one-cycle `frame_pulse`.

A 3-bit mask takes any class out of the scan while the system runs. When the handshake is enabled, the scheduler stops after each frame. It waits for a controller to signal, by toggling an asynchronous ready line, that the beam pattern for the next frame has been loaded. A watchdog ends a stall that lasts too long: the scan moves on and a sticky fault flag is set. Only reset clears that flag.

Top module: `chirp_sched_top`

## Requirements
- R1: After a synchronous active-high reset, `chirp_pulse`, `frame_pulse` and `wd_fired` are 0 and `wave_sel` is SHORT (2'b00).
- R2: No `chirp_pulse` appears in the cycle after any cycle where `run_en` is low. Dropping `run_en` in the middle of a frame stops the scan. Raising it again restarts from chirp 0 of the first enabled class.
- R3: Field i of `chirp_len` and `listen_len` (bits [i*DUR_W +: DUR_W]; i=0 SHORT, 1 MEDIUM, 2 LONG) sets the lengths for class i. A chirp's transmit phase lasts max(chirp_len,1) cycles and its listen phase lasts max(listen_len,1) cycles. Consecutive `chirp_pulse`s inside a sub-frame are therefore spaced by the sum of the two. `chirp_pulse` is high for exactly one cycle.
- R4: `wave_sel` encodes SHORT=2'b00, MEDIUM=2'b01 and LONG=2'b10. Each enabled class produces CHIRPS_PER_SUB chirps in a row. Classes run in the order SHORT, MEDIUM, LONG, so a frame with all classes enabled has 48 chirps.
- R5: `sub_mask` bit 0 enables SHORT, bit 1 enables MEDIUM and bit 2 enables LONG. Disabled classes are skipped. With the mask all zero the block stays idle and produces no pulses.
- R6: `frame_pulse` is high for one cycle. It comes in the cycle after the last listen cycle of the last enabled sub-frame. With `hs_en` low, the first `chirp_pulse` of the next frame falls in the same cycle.
- R7: With `hs_en` high, the block stalls after `frame_pulse` and holds with no chirps until it sees a transition, rising or falling, on `beam_ready_async`. A change made between two clock edges gives a `chirp_pulse` after the third following rising edge.
- R8: A transition of `beam_ready_async` that happens while chirps are running has no effect on a later stall.
- R9: A stall with no transition lasts exactly WD_LIMIT cycles. The next frame then starts, and `wd_fired` rises in the same cycle as its first `chirp_pulse`.
- R10: Once `wd_fired` is set, it stays set while `run_en` is low. Only reset clears it.
- R11: Clearing `hs_en` during a stall starts the next frame at the next clock edge. Clearing `run_en` during a stall returns the block to idle.
- R12: `wave_sel` changes only in a cycle where `chirp_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Master enable; low holds the scheduler idle |
| sub_mask | input | 3 | Class enables (bit0 SHORT, bit1 MEDIUM, bit2 LONG) |
| chirp_len | input | 3*DUR_W | Transmit-phase length per class, in cycles |
| listen_len | input | 3*DUR_W | Listen-phase length per class, in cycles |
| hs_en | input | 1 | Enables the stall between frames |
| beam_ready_async | input | 1 | Asynchronous ready line; any transition releases a stall |
| chirp_pulse | output | 1 | One-cycle strobe at the start of each chirp |
| wave_sel | output | 2 | Waveform class of the current chirp |
| frame_pulse | output | 1 | One-cycle strobe at the end of each frame |
| wd_fired | output | 1 | Sticky flag: a stall was ended by the watchdog |

## Verification
A wrong chirp index or phase timer shifts the next `chirp_pulse` or `wave_sel` change by at least one cycle, and the scan order can slip by a whole sub-frame. The reference model compares every cycle, so such an error is caught at the first pulse that lands in the wrong place. A broken stall state or ready synchroniser shows up in the next frame gap: a chirp arrives during the hold, or release comes at the wrong distance after the toggle. A broken watchdog changes the stall length from WD_LIMIT cycles, or leaves `wd_fired` wrong after `run_en` is dropped.

// File: rtl/chirp_sched_pkg.sv
package chirp_sched_pkg;

    localparam int NUM_WAVES = 3;

    typedef enum logic [1:0] {
        WAVE_SHORT  = 2'b00,
        WAVE_MEDIUM = 2'b01,
        WAVE_LONG   = 2'b10
    } wave_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHIRP,
        ST_LISTEN,
        ST_WAIT
    } sched_st_e;

    typedef struct packed {
        logic  found;
        wave_e wave;
    } pick_t;

    // Lowest enabled class whose index is at least lo.
    function automatic pick_t pick_from(input logic [NUM_WAVES-1:0] mask, input int lo);
        pick_t p;
        p.found = 1'b0;
        p.wave  = WAVE_SHORT;
        for (int i = NUM_WAVES - 1; i >= 0; i--) begin
            if (mask[i] && (i >= lo)) begin
                p.found = 1'b1;
                p.wave  = wave_e'(i[1:0]);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sched_ready_sync.sv
module sched_ready_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_pulse
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign edge_pulse = sync_q ^ prev_q;

    // R7
    edge_follows_change_chk: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |-> (sync_q != $past(sync_q)));

endmodule

// File: rtl/sched_beam_watchdog.sv
module sched_beam_watchdog #(
    parameter int WD_LIMIT = 8_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic in_wait,
    input  logic take_timeout,
    output logic expire,
    output logic fired
);
    localparam int CW = $clog2(WD_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(WD_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = in_wait && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !in_wait) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fired <= 1'b0;
        end else if (take_timeout) begin
            fired <= 1'b1;
        end
    end

    // R9
    wd_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R9
    wd_timeout_needs_expire_chk: assert property (@(posedge clk) disable iff (rst)
        take_timeout |-> expire);

    // R10
    wd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fired |=> fired);

endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
    import chirp_sched_pkg::*;
#(
    parameter int DUR_W          = 16,
    parameter int CHIRPS_PER_SUB = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 run_en,
    input  logic [NUM_WAVES-1:0]                 sub_mask,
    input  logic [NUM_WAVES-1:0][DUR_W-1:0]      chirp_load,
    input  logic [NUM_WAVES-1:0][DUR_W-1:0]      listen_load,
    input  logic                                 hs_en,
    input  logic                                 ready_edge,
    input  logic                                 wd_expire,
    output logic                                 in_wait,
    output logic                                 take_timeout,
    output logic                                 chirp_pulse,
    output logic [1:0]                           wave_sel,
    output logic                                 frame_pulse
);
    localparam int IDX_W = (CHIRPS_PER_SUB > 1) ? $clog2(CHIRPS_PER_SUB) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHIRPS_PER_SUB - 1);

    sched_st_e         st_q, st_n;
    logic [DUR_W-1:0]  tmr_q, tmr_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    wave_e             cur_q, cur_n;
    logic              cp_q, cp_n;
    logic              fp_q, fp_n;

    pick_t pick_first;
    pick_t pick_after;
    logic  go;
    wave_e go_wave;

    assign pick_first = pick_from(sub_mask, 0);
    assign pick_after = pick_from(sub_mask, int'(cur_q) + 1);

    always_comb begin
        st_n         = st_q;
        tmr_n        = tmr_q;
        idx_n        = idx_q;
        cur_n        = cur_q;
        cp_n         = 1'b0;
        fp_n         = 1'b0;
        go           = 1'b0;
        go_wave      = cur_q;
        take_timeout = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                idx_n = '0;
                if (run_en && pick_first.found) begin
                    go      = 1'b1;
                    go_wave = pick_first.wave;
                end
            end
            ST_CHIRP: begin
                if (!run_en) begin
                    st_n  = ST_IDLE;
                    idx_n = '0;
                end else if (tmr_q == '0) begin
                    st_n  = ST_LISTEN;
                    tmr_n = listen_load[cur_q];
                end else begin
                    tmr_n = tmr_q - 1'b1;
                end
            end
            ST_LISTEN: begin
                if (!run_en) begin
                    st_n  = ST_IDLE;
                    idx_n = '0;
                end else if (tmr_q != '0) begin
                    tmr_n = tmr_q - 1'b1;
                end else if (idx_q != IDX_LAST) begin
                    idx_n   = idx_q + 1'b1;
                    go      = 1'b1;
                    go_wave = cur_q;
                end else begin
                    idx_n = '0;
                    if (pick_after.found) begin
                        go      = 1'b1;
                        go_wave = pick_after.wave;
                    end else begin
                        fp_n = 1'b1;
                        if (!pick_first.found) begin
                            st_n = ST_IDLE;
                        end else if (hs_en) begin
                            st_n = ST_WAIT;
                        end else begin
                            go      = 1'b1;
                            go_wave = pick_first.wave;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (!run_en || !pick_first.found) begin
                    st_n = ST_IDLE;
                end else if (!hs_en || ready_edge) begin
                    go      = 1'b1;
                    go_wave = pick_first.wave;
                end else if (wd_expire) begin
                    go           = 1'b1;
                    go_wave      = pick_first.wave;
                    take_timeout = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (go) begin
            st_n  = ST_CHIRP;
            cur_n = go_wave;
            tmr_n = chirp_load[go_wave];
            cp_n  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
            idx_q <= '0;
            cur_q <= WAVE_SHORT;
            cp_q  <= 1'b0;
            fp_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            tmr_q <= tmr_n;
            idx_q <= idx_n;
            cur_q <= cur_n;
            cp_q  <= cp_n;
            fp_q  <= fp_n;
        end
    end

    assign in_wait     = (st_q == ST_WAIT);
    assign chirp_pulse = cp_q;
    assign frame_pulse = fp_q;
    assign wave_sel    = cur_q;

    // R2
    run_low_no_chirp_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !chirp_pulse);

    // R6
    frame_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> !frame_pulse);

    // R3
    chirp_single_chk: assert property (@(posedge clk) disable iff (rst)
        chirp_pulse |=> !chirp_pulse);

    // R12
    wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chirp_pulse |-> $stable(wave_sel));

    // R4
    wave_legal_chk: assert property (@(posedge clk) disable iff (rst)
        wave_sel != 2'b11);

    // R7
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_wait |-> !chirp_pulse);

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_mask == '0 && st_q == ST_IDLE) |=> !chirp_pulse);

endmodule

// File: rtl/chirp_sched_top.sv
module chirp_sched_top
    import chirp_sched_pkg::*;
#(
    parameter int DUR_W          = 16,
    parameter int CHIRPS_PER_SUB = 16,
    parameter int WD_LIMIT       = 8_000_000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run_en,
    input  logic [NUM_WAVES-1:0]       sub_mask,
    input  logic [NUM_WAVES*DUR_W-1:0] chirp_len,
    input  logic [NUM_WAVES*DUR_W-1:0] listen_len,
    input  logic                       hs_en,
    input  logic                       beam_ready_async,
    output logic                       chirp_pulse,
    output logic [1:0]                 wave_sel,
    output logic                       frame_pulse,
    output logic                       wd_fired
);
    logic [NUM_WAVES-1:0][DUR_W-1:0] chirp_load;
    logic [NUM_WAVES-1:0][DUR_W-1:0] listen_load;
    logic ready_edge;
    logic in_wait;
    logic take_timeout;
    logic wd_expire;

    // Timers count down to zero, so load length-1; zero is treated as one cycle.
    for (genvar g = 0; g < NUM_WAVES; g++) begin : g_load
        logic [DUR_W-1:0] c_raw;
        logic [DUR_W-1:0] l_raw;
        assign c_raw = chirp_len[g*DUR_W +: DUR_W];
        assign l_raw = listen_len[g*DUR_W +: DUR_W];
        assign chirp_load[g]  = (c_raw == '0) ? '0 : c_raw - 1'b1;
        assign listen_load[g] = (l_raw == '0) ? '0 : l_raw - 1'b1;
    end

    sched_ready_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (beam_ready_async),
        .edge_pulse (ready_edge)
    );

    sched_beam_watchdog #(
        .WD_LIMIT (WD_LIMIT)
    ) u_wdog (
        .clk          (clk),
        .rst          (rst),
        .in_wait      (in_wait),
        .take_timeout (take_timeout),
        .expire       (wd_expire),
        .fired        (wd_fired)
    );

    sched_fsm #(
        .DUR_W          (DUR_W),
        .CHIRPS_PER_SUB (CHIRPS_PER_SUB)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .run_en       (run_en),
        .sub_mask     (sub_mask),
        .chirp_load   (chirp_load),
        .listen_load  (listen_load),
        .hs_en        (hs_en),
        .ready_edge   (ready_edge),
        .wd_expire    (wd_expire),
        .in_wait      (in_wait),
        .take_timeout (take_timeout),
        .chirp_pulse  (chirp_pulse),
        .wave_sel     (wave_sel),
        .frame_pulse  (frame_pulse)
    );

endmodule

// File: tb/chirp_sched_top_tb.sv
module chirp_sched_top_tb;
    localparam int DUR_W = 8;
    localparam int NCH   = 16;
    localparam int WD    = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic [2:0] sub_mask = 3'b111;
    logic [3*DUR_W-1:0] chirp_len;
    logic [3*DUR_W-1:0] listen_len;
    logic hs_en = 1'b0;
    logic rdy = 1'b0;
    logic chirp_pulse, frame_pulse, wd_fired;
    logic [1:0] wave_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chirp_sched_top #(.DUR_W(DUR_W), .CHIRPS_PER_SUB(NCH), .WD_LIMIT(WD)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .sub_mask(sub_mask),
        .chirp_len(chirp_len), .listen_len(listen_len), .hs_en(hs_en),
        .beam_ready_async(rdy), .chirp_pulse(chirp_pulse), .wave_sel(wave_sel),
        .frame_pulse(frame_pulse), .wd_fired(wd_fired)
    );

    // ---------------- reference model ----------------
    int md = 0;   // 0 idle, 1 running, 2 stalled
    int cls = 0, nth = 0, pos = 0, wc = 0;
    int s1 = 0, s2 = 0, s3 = 0;
    int e_cp = 0, e_fp = 0, e_ws = 0, e_wd = 0;

    function automatic int fld(input logic [3*DUR_W-1:0] v, input int c);
        int x;
        x = int'(v[c*DUR_W +: DUR_W]);
        return (x < 1) ? 1 : x;
    endfunction

    function automatic int next_on(input logic [2:0] m, input int lo);
        for (int i = lo; i < 3; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic kick(input int c);
        md = 1; cls = c; pos = 0; e_cp = 1; e_ws = c;
    endtask

    always @(posedge clk) begin
        int f;
        int edge_now;
        if (rst) begin
            md = 0; cls = 0; nth = 0; pos = 0; wc = 0;
            s1 = 0; s2 = 0; s3 = 0;
            e_cp = 0; e_fp = 0; e_ws = 0; e_wd = 0;
        end else begin
            edge_now = (s2 != s3);
            s3 = s2; s2 = s1; s1 = int'(rdy);
            e_cp = 0; e_fp = 0;
            f = next_on(sub_mask, 0);
            case (md)
                0: begin
                    nth = 0;
                    if (run_en && f >= 0) kick(f);
                end
                1: begin
                    if (!run_en) begin
                        md = 0; nth = 0;
                    end else begin
                        pos++;
                        if (pos == fld(chirp_len, cls) + fld(listen_len, cls)) begin
                            nth++;
                            if (nth < NCH) kick(cls);
                            else begin
                                nth = 0;
                                if (next_on(sub_mask, cls + 1) >= 0) kick(next_on(sub_mask, cls + 1));
                                else begin
                                    e_fp = 1;
                                    if (f < 0) md = 0;
                                    else if (hs_en) begin md = 2; wc = 0; end
                                    else kick(f);
                                end
                            end
                        end
                    end
                end
                default: begin
                    wc++;
                    if (!run_en || f < 0) md = 0;
                    else if (!hs_en || edge_now) kick(f);
                    else if (wc == WD) begin kick(f); e_wd = 1; end
                end
            endcase
        end
    end

    // ---------------- monitor: compare every cycle ----------------
    int n_cp = 0, n_fp = 0;
    int n_cls[3] = '{0, 0, 0};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(int'(chirp_pulse) == e_cp, "R3 chirp_pulse", int'(chirp_pulse), e_cp);
            check(int'(wave_sel) == e_ws, "R4/R12 wave_sel", int'(wave_sel), e_ws);
            check(int'(frame_pulse) == e_fp, "R6 frame_pulse", int'(frame_pulse), e_fp);
            check(int'(wd_fired) == e_wd, "R9/R10 wd_fired", int'(wd_fired), e_wd);
            if (chirp_pulse) begin
                n_cp++;
                if (wave_sel < 2'd3) n_cls[wave_sel]++;
            end
            if (frame_pulse) n_fp++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wait_fp(input string tag);
        int k;
        k = 0;
        while (!frame_pulse && k < 2000) begin step(1); k++; end
        check(frame_pulse == 1'b1, tag, int'(frame_pulse), 1);
    endtask

    function automatic int steps_to_cp_fn(input int dummy);
        return dummy;
    endfunction

    task automatic steps_to_cp(output int n);
        n = 0;
        do begin step(1); n++; end while (!chirp_pulse && n < 1000);
    endtask

    initial begin
        int n0, n, c0;
        chirp_len  = {8'd2, 8'd4, 8'd3};
        listen_len = {8'd5, 8'd3, 8'd2};
        step(4);
        check(chirp_pulse == 0 && frame_pulse == 0 && wd_fired == 0 && wave_sel == 2'b00,
              "R1 reset state", int'({chirp_pulse, frame_pulse, wd_fired, wave_sel}), 0);
        rst = 1'b0;

        // R2: disabled -> nothing
        step(50);
        check(n_cp == 0, "R2 idle while run_en low", n_cp, 0);

        // R4/R7: full frame with handshake, then stall
        hs_en = 1'b1; run_en = 1'b1;
        n_cls = '{0, 0, 0}; n0 = n_cp;
        wait_fp("R6 first frame_pulse");
        check(n_cp - n0 == 48, "R4 chirps per frame", n_cp - n0, 48);
        check(n_cls[0] == 16 && n_cls[1] == 16 && n_cls[2] == 16, "R4 per-class count",
              n_cls[1], 16);
        n0 = n_cp;
        step(200);
        check(n_cp == n0, "R7 200-cycle hold", n_cp - n0, 0);

        // R7: rising transition releases after three edges
        rdy = 1'b1;
        steps_to_cp(n);
        check(n == 3, "R7 release on rising", n, 3);

        // R8: toggle while running is ignored
        step(20);
        rdy = 1'b0;
        wait_fp("R6 second frame_pulse");
        n0 = n_cp;
        step(150);
        check(n_cp == n0, "R8 earlier toggle ignored", n_cp - n0, 0);

        // R7: falling transition releases; R5 mask change during stall
        sub_mask = 3'b101;
        n_cls = '{0, 0, 0}; n0 = n_cp;
        rdy = 1'b1; step(1); rdy = 1'b0; // pulse-wide toggle pair counts as transitions
        wait_fp("R6 masked frame_pulse");
        check(n_cls[1] == 0 && n_cls[0] == 16 && n_cls[2] == 16, "R5 MEDIUM skipped",
              n_cls[1], 0);

        // R9: watchdog ends the stall
        n = 0;
        steps_to_cp(n);
        check(n == WD, "R9 watchdog stall length", n, WD);
        check(wd_fired == 1'b1, "R9 wd_fired set", int'(wd_fired), 1);

        // R2: drop mid-frame
        step(30);
        run_en = 1'b0;
        n0 = n_cp;
        step(40);
        check(n_cp == n0, "R2 drop mid-frame", n_cp - n0, 0);
        check(wd_fired == 1'b1, "R10 sticky across disable", int'(wd_fired), 1);

        // R11: clearing hs_en during stall
        run_en = 1'b1;
        wait_fp("R6 frame before hs release");
        step(10);
        hs_en = 1'b0;
        steps_to_cp(n);
        check(n == 1, "R11 hs_en clear releases", n, 1);

        // R11: run_en low during stall
        hs_en = 1'b1;
        wait_fp("R6 frame before run drop");
        step(5);
        run_en = 1'b0;
        step(2);
        run_en = 1'b1; hs_en = 1'b0;
        steps_to_cp(n);
        check(n == 1 && wave_sel == 2'b00, "R11 run drop returns idle then restart", n, 1);

        // R5: all-zero mask
        run_en = 1'b0; step(2);
        sub_mask = 3'b000; run_en = 1'b1;
        n0 = n_cp; c0 = n_fp;
        step(60);
        check(n_cp == n0 && n_fp == c0, "R5 zero mask idle", n_cp - n0, 0);

        // R3: period for SHORT only, normal and zero lengths
        run_en = 1'b0; step(2);
        sub_mask = 3'b001; run_en = 1'b1;
        steps_to_cp(n);
        steps_to_cp(n);
        check(n == 5, "R3 chirp period 3+2", n, 5);
        run_en = 1'b0; step(2);
        chirp_len = {8'd2, 8'd4, 8'd0}; listen_len = {8'd5, 8'd3, 8'd0};
        run_en = 1'b1;
        steps_to_cp(n);
        steps_to_cp(n);
        check(n == 2, "R3 zero lengths clamp to 1", n, 2);
        n = steps_to_cp_fn(0);

        // R1/R10: reset clears sticky flag
        rst = 1'b1; step(2);
        check(wd_fired == 1'b0 && chirp_pulse == 1'b0, "R10 reset clears wd_fired",
              int'(wd_fired), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule